// File: doc/BRIEF.md
# Sideband Message Record Assembler

This block watches a byte-wide sideband channel on which received link messages are streamed one byte per clock. A message arrives as one unbroken run of cycles with the valid strobe high, with the 5-bit message code held on a type bus and one parameter byte on the data bus per cycle. At least one strobe-low cycle separates two runs. The block gathers the bytes of a run into a flat record: the message code, a 16-bit requester ID, a 16-bit vendor ID, a 32-bit payload and a data-present flag.

The expected run length is derived from the code. Error-class, interrupt, power-management and unlock messages carry only the requester ID. Slot-power and latency-report messages also carry four payload bytes. Vendor messages carry the requester ID and a vendor ID, and may carry four payload bytes; their run length tells whether a payload is present. When the run closes, the block either publishes the record with a one-cycle completion pulse or raises one of two one-cycle error pulses. The published record holds its value until the next completion.

Downstream logic samples the record on the completion pulse. The two error pulses are meant for error counters or for debug capture.

Top module: `msg_deser`

## Requirements
- R1: While reset is asserted and after reset is released, `rec_done`, `len_err` and `unk_err` are low and every record output is zero until the first completed message.
- R2: Codes 0 to 14 and code 18 complete only as 2-beat runs: `rec_reqid` = {beat 1, beat 2}, `rec_vendid` = 0, `rec_payload` = 0, `rec_has_data` = 0 and `rec_type` equals the code.
- R3: Code 15 completes only as a 6-beat run: `rec_payload` = {beat 6, beat 5, beat 4, beat 3}, so the least significant byte arrives first.
- R4: Code 16 completes only as a 6-beat run: `rec_payload[15:0]` = {beat 4, beat 3} and `rec_payload[31:16]` = {beat 6, beat 5}.
- R5: Codes 19 and 20 as a 4-beat run complete with `rec_vendid` = {beat 4, beat 3}, `rec_has_data` = 0 and `rec_payload` = 0.
- R6: Codes 19 and 20 as an 8-beat run complete with `rec_vendid` = {beat 4, beat 3}, `rec_has_data` = 1 and `rec_payload` = {beat 8, beat 7, beat 6, beat 5}. `rec_has_data` is never 1 with any other code.
- R7: `rec_done` is high for exactly one cycle: the cycle after the first strobe-low cycle that ends the run.
- R8: A run whose length does not match its code raises `len_err` for one cycle in the same cycle position as `rec_done` would have taken. No completion follows and the record outputs keep their previous values.
- R9: A run in which the type bus changes after beat 1 raises `len_err`, even when the length would have been correct. No completion follows and the record is unchanged.
- R10: A run whose beat-1 code is 17 or 21 to 31 raises `unk_err` for one cycle, whatever its length or later codes. No completion follows and the record is unchanged.
- R11: At most one of `rec_done`, `len_err` and `unk_err` is high in any cycle. Record outputs change only in a cycle in which `rec_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | Message strobe; one run of high cycles per message |
| rx_type | input | 5 | Message code, valid while the strobe is high |
| rx_data | input | 8 | Parameter byte for the current beat |
| rec_done | output | 1 | One-cycle pulse: the record holds a newly completed message |
| rec_type | output | 5 | Code of the last completed message |
| rec_reqid | output | 16 | Requester ID: bus number in the upper byte |
| rec_vendid | output | 16 | Vendor ID of vendor messages, otherwise zero |
| rec_payload | output | 32 | Assembled payload, otherwise zero |
| rec_has_data | output | 1 | Vendor message carried a payload |
| len_err | output | 1 | One-cycle pulse: framing error (length or mid-run code change) |
| unk_err | output | 1 | One-cycle pulse: reserved or undefined code |

## Verification
The assertions assume that the type and data buses are only meaningful while `rx_vld` is high, and that every run ends with at least one low cycle before the next run begins. Under that assumption a closing pulse can always be tied to a preceding low strobe cycle. The stimulus sends each message from a task that drives one beat per cycle and always adds a single low cycle afterwards, so runs are placed back to back with the minimum gap. The bench deliberately breaks length and code consistency, but never the separation rule.

// File: rtl/msg_deser_pkg.sv
package msg_deser_pkg;

  localparam int TYPE_W    = 5;
  localparam int BYTE_W    = 8;
  localparam int CNT_W     = 4;
  localparam int HDR_BEATS = 2;
  localparam int VID_BYTES = 2;
  localparam int PAY_BYTES = 4;
  localparam int SIX_LEN   = HDR_BEATS + PAY_BYTES;
  localparam int VND_SHORT = HDR_BEATS + VID_BYTES;
  localparam int VND_LONG  = VND_SHORT + PAY_BYTES;

  typedef enum logic [1:0] {
    CLS_SHORT,
    CLS_SIX,
    CLS_VEND,
    CLS_UNK
  } msg_cls_e;

  function automatic msg_cls_e classify(input logic [TYPE_W-1:0] t);
    msg_cls_e c;
    if (t <= TYPE_W'(14) || t == TYPE_W'(18)) c = CLS_SHORT;
    else if (t == TYPE_W'(15) || t == TYPE_W'(16)) c = CLS_SIX;
    else if (t == TYPE_W'(19) || t == TYPE_W'(20)) c = CLS_VEND;
    else c = CLS_UNK;
    return c;
  endfunction

endpackage

// File: rtl/msg_run_track.sv
module msg_run_track
  import msg_deser_pkg::*;
#(
  parameter int T_W = TYPE_W,
  parameter int C_W = CNT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vld,
  input  logic [T_W-1:0] type_in,
  output logic           first_beat,
  output logic           run_end,
  output logic [C_W-1:0] beat_idx,
  output logic [C_W-1:0] beat_cnt,
  output logic [T_W-1:0] run_type,
  output logic           type_mism
);

  logic           in_run_q, in_run_d;
  logic [C_W-1:0] cnt_q, cnt_d;
  logic [T_W-1:0] type_q, type_d;
  logic           mism_q, mism_d;
  logic           en;

  always_comb begin
    first_beat = vld & ~in_run_q;
    run_end    = ~vld & in_run_q;
    if (first_beat)           beat_idx = C_W'(1);
    else if (&cnt_q)          beat_idx = cnt_q;
    else                      beat_idx = cnt_q + C_W'(1);
    run_type  = first_beat ? type_in : type_q;
    beat_cnt  = cnt_q;
    type_mism = mism_q;
  end

  always_comb begin
    en       = vld | in_run_q;
    in_run_d = vld;
    cnt_d    = vld ? beat_idx : cnt_q;
    type_d   = run_type;
    if (first_beat)  mism_d = 1'b0;
    else if (vld)    mism_d = mism_q | (type_in != type_q);
    else             mism_d = mism_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_run_q <= 1'b0;
      cnt_q    <= '0;
      type_q   <= '0;
      mism_q   <= 1'b0;
    end else if (en) begin
      in_run_q <= in_run_d;
      cnt_q    <= cnt_d;
      type_q   <= type_d;
      mism_q   <= mism_d;
    end
  end

endmodule

// File: rtl/msg_field_asm.sv
module msg_field_asm
  import msg_deser_pkg::*;
#(
  parameter int B_W = BYTE_W,
  parameter int C_W = CNT_W,
  localparam int RID_W = HDR_BEATS * B_W,
  localparam int VID_W = VID_BYTES * B_W,
  localparam int PAY_W = PAY_BYTES * B_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic             first_beat,
  input  logic [C_W-1:0]   beat_idx,
  input  msg_cls_e         cls,
  input  logic [B_W-1:0]   data,
  output logic [RID_W-1:0] rid,
  output logic [VID_W-1:0] vid,
  output logic [PAY_W-1:0] pay
);

  logic [RID_W-1:0] rid_q, rid_d;
  logic [VID_W-1:0] vid_q, vid_d;
  logic [PAY_W-1:0] pay_q, pay_d;

  always_comb begin
    rid_d = first_beat ? '0 : rid_q;
    vid_d = first_beat ? '0 : vid_q;
    pay_d = first_beat ? '0 : pay_q;
    if (vld) begin
      for (int h = 0; h < HDR_BEATS; h++) begin
        if (beat_idx == C_W'(h + 1))
          rid_d[(HDR_BEATS-1-h)*B_W +: B_W] = data;
      end
      for (int v = 0; v < VID_BYTES; v++) begin
        if (cls == CLS_VEND && beat_idx == C_W'(HDR_BEATS + 1 + v))
          vid_d[v*B_W +: B_W] = data;
      end
      for (int p = 0; p < PAY_BYTES; p++) begin
        if (cls == CLS_SIX && beat_idx == C_W'(HDR_BEATS + 1 + p))
          pay_d[p*B_W +: B_W] = data;
        if (cls == CLS_VEND && beat_idx == C_W'(VND_SHORT + 1 + p))
          pay_d[p*B_W +: B_W] = data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rid_q <= '0;
      vid_q <= '0;
      pay_q <= '0;
    end else if (vld) begin
      rid_q <= rid_d;
      vid_q <= vid_d;
      pay_q <= pay_d;
    end
  end

  assign rid = rid_q;
  assign vid = vid_q;
  assign pay = pay_q;

endmodule

// File: rtl/msg_frame_chk.sv
module msg_frame_chk
  import msg_deser_pkg::*;
#(
  parameter int C_W = CNT_W
) (
  input  msg_cls_e       cls,
  input  logic [C_W-1:0] beat_cnt,
  input  logic           type_mism,
  output logic           good,
  output logic           len_bad,
  output logic           unk,
  output logic           has_data
);

  logic len_ok;

  always_comb begin
    unique case (cls)
      CLS_SHORT: len_ok = (beat_cnt == C_W'(HDR_BEATS));
      CLS_SIX:   len_ok = (beat_cnt == C_W'(SIX_LEN));
      CLS_VEND:  len_ok = (beat_cnt == C_W'(VND_SHORT)) ||
                          (beat_cnt == C_W'(VND_LONG));
      default:   len_ok = 1'b0;
    endcase
    unk      = (cls == CLS_UNK);
    len_bad  = ~unk & (type_mism | ~len_ok);
    good     = ~unk & ~type_mism & len_ok;
    has_data = (cls == CLS_VEND) && (beat_cnt == C_W'(VND_LONG));
  end

endmodule

// File: rtl/msg_deser.sv
module msg_deser
  import msg_deser_pkg::*;
#(
  parameter int T_W = TYPE_W,
  parameter int B_W = BYTE_W,
  parameter int C_W = CNT_W,
  localparam int RID_W = HDR_BEATS * B_W,
  localparam int VID_W = VID_BYTES * B_W,
  localparam int PAY_W = PAY_BYTES * B_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_vld,
  input  logic [T_W-1:0]   rx_type,
  input  logic [B_W-1:0]   rx_data,
  output logic             rec_done,
  output logic [T_W-1:0]   rec_type,
  output logic [RID_W-1:0] rec_reqid,
  output logic [VID_W-1:0] rec_vendid,
  output logic [PAY_W-1:0] rec_payload,
  output logic             rec_has_data,
  output logic             len_err,
  output logic             unk_err
);

  logic             first_beat, run_end;
  logic [C_W-1:0]   beat_idx, beat_cnt;
  logic [T_W-1:0]   run_type;
  logic             type_mism;
  msg_cls_e         cls;
  logic [RID_W-1:0] stg_rid;
  logic [VID_W-1:0] stg_vid;
  logic [PAY_W-1:0] stg_pay;
  logic             f_good, f_len, f_unk, f_data;

  msg_run_track #(.T_W(T_W), .C_W(C_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .vld        (rx_vld),
    .type_in    (rx_type),
    .first_beat (first_beat),
    .run_end    (run_end),
    .beat_idx   (beat_idx),
    .beat_cnt   (beat_cnt),
    .run_type   (run_type),
    .type_mism  (type_mism)
  );

  assign cls = classify(run_type);

  msg_field_asm #(.B_W(B_W), .C_W(C_W)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .vld        (rx_vld),
    .first_beat (first_beat),
    .beat_idx   (beat_idx),
    .cls        (cls),
    .data       (rx_data),
    .rid        (stg_rid),
    .vid        (stg_vid),
    .pay        (stg_pay)
  );

  msg_frame_chk #(.C_W(C_W)) u_frame (
    .cls       (cls),
    .beat_cnt  (beat_cnt),
    .type_mism (type_mism),
    .good      (f_good),
    .len_bad   (f_len),
    .unk       (f_unk),
    .has_data  (f_data)
  );

  logic done_q, done_d, len_q, len_d, unk_q, unk_d;
  logic [T_W-1:0]   type_q;
  logic [RID_W-1:0] rid_q;
  logic [VID_W-1:0] vid_q;
  logic [PAY_W-1:0] pay_q;
  logic             hd_q;

  always_comb begin
    done_d = run_end & f_good;
    len_d  = run_end & f_len;
    unk_d  = run_end & f_unk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      len_q  <= 1'b0;
      unk_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      len_q  <= len_d;
      unk_q  <= unk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      rid_q  <= '0;
      vid_q  <= '0;
      pay_q  <= '0;
      hd_q   <= 1'b0;
    end else if (done_d) begin
      type_q <= run_type;
      rid_q  <= stg_rid;
      vid_q  <= stg_vid;
      pay_q  <= stg_pay;
      hd_q   <= f_data;
    end
  end

  assign rec_done     = done_q;
  assign len_err      = len_q;
  assign unk_err      = unk_q;
  assign rec_type     = type_q;
  assign rec_reqid    = rid_q;
  assign rec_vendid   = vid_q;
  assign rec_payload  = pay_q;
  assign rec_has_data = hd_q;

endmodule

// File: rtl/msg_deser_chk.sv
module msg_deser_chk #(
  parameter int T_W = 5,
  parameter int RID_W = 16,
  parameter int VID_W = 16,
  parameter int PAY_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_vld,
  input logic             rec_done,
  input logic             len_err,
  input logic             unk_err,
  input logic [T_W-1:0]   rec_type,
  input logic [RID_W-1:0] rec_reqid,
  input logic [VID_W-1:0] rec_vendid,
  input logic [PAY_W-1:0] rec_payload,
  input logic             rec_has_data
);

  // R11
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rec_done, len_err, unk_err}));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |=> !rec_done);

  // R7
  done_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_done || len_err || unk_err) |-> !$past(rx_vld));

  // R11
  record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_done |-> ($stable(rec_type) && $stable(rec_reqid) && $stable(rec_vendid)
                   && $stable(rec_payload) && $stable(rec_has_data)));

  // R6
  has_data_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_has_data |-> (rec_type == T_W'(19) || rec_type == T_W'(20)));

  // R10
  known_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |-> !(rec_type == T_W'(17) || rec_type >= T_W'(21)));

endmodule

bind msg_deser msg_deser_chk #(
  .T_W(T_W), .RID_W(RID_W), .VID_W(VID_W), .PAY_W(PAY_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_vld       (rx_vld),
  .rec_done     (rec_done),
  .len_err      (len_err),
  .unk_err      (unk_err),
  .rec_type     (rec_type),
  .rec_reqid    (rec_reqid),
  .rec_vendid   (rec_vendid),
  .rec_payload  (rec_payload),
  .rec_has_data (rec_has_data)
);

// File: tb/msg_deser_bench.sv
module msg_deser_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, rx_vld;
  logic [4:0]  rx_type;
  logic [7:0]  rx_data;
  logic        rec_done, rec_has_data, len_err, unk_err;
  logic [4:0]  rec_type;
  logic [15:0] rec_reqid, rec_vendid;
  logic [31:0] rec_payload;

  msg_deser u_msg_deser (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_type(rx_type), .rx_data(rx_data),
    .rec_done(rec_done), .rec_type(rec_type), .rec_reqid(rec_reqid),
    .rec_vendid(rec_vendid), .rec_payload(rec_payload), .rec_has_data(rec_has_data),
    .len_err(len_err), .unk_err(unk_err)
  );

  typedef struct {
    int          cyc;
    int          kind;   // 0 done, 1 length error, 2 unknown code
    logic [4:0]  t;
    logic [15:0] rid;
    logic [15:0] vid;
    logic [31:0] pay;
    logic        hd;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_good;
  int   total = 0;
  int   bad   = 0;
  int   cyc   = 0;
  bit   ended = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Driver: one beat per cycle, then a single low cycle; expectation is pushed.
  task automatic send(input logic [4:0] t0, input logic [4:0] t1, input int n,
                      input int seed, input int kind);
    logic [7:0] b [0:15];
    exp_t e;
    for (int i = 0; i < 16; i++) b[i] = 8'(seed + i * 29 + 3);
    e.kind = kind; e.t = t0; e.rid = {b[0], b[1]};
    e.vid = '0; e.pay = '0; e.hd = 1'b0;
    if (t0 == 5'd15 || t0 == 5'd16) e.pay = {b[5], b[4], b[3], b[2]};
    if (t0 == 5'd19 || t0 == 5'd20) begin
      e.vid = {b[3], b[2]};
      if (n == 8) begin e.hd = 1'b1; e.pay = {b[7], b[6], b[5], b[4]}; end
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_vld = 1'b1; rx_type = (i == 0) ? t0 : t1; rx_data = b[i];
    end
    @(negedge clk);
    rx_vld = 1'b0; rx_type = '0; rx_data = '0;
    e.cyc = cyc + 1;
    exp_q.push_back(e);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && (rec_done || len_err || unk_err)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "unexpected pulse", {rec_done, len_err, unk_err}, 0);
      end else begin
        exp_t e;
        exp_t r;
        e = exp_q.pop_front();
        check(cyc == e.cyc, "R7", "pulse cycle", cyc, e.cyc);
        case (e.kind)
          0: check(rec_done && !len_err && !unk_err, "R7", "done pulse",
                   {rec_done, len_err, unk_err}, 3'b100);
          1: check(len_err && !rec_done && !unk_err, "R8 R9", "len_err pulse",
                   {rec_done, len_err, unk_err}, 3'b010);
          default: check(unk_err && !rec_done && !len_err, "R10", "unk_err pulse",
                   {rec_done, len_err, unk_err}, 3'b001);
        endcase
        if (e.kind == 0) begin
          last_good = e;
          r = e;
        end else begin
          r = last_good;
        end
        check(rec_type == r.t, "R2 R11", "rec_type", rec_type, r.t);
        check(rec_reqid == r.rid, "R2", "rec_reqid", rec_reqid, r.rid);
        check(rec_vendid == r.vid, "R5", "rec_vendid", rec_vendid, r.vid);
        check(rec_payload == r.pay, "R3 R4 R6", "rec_payload", rec_payload, r.pay);
        check(rec_has_data == r.hd, "R6", "rec_has_data", rec_has_data, r.hd);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R7", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rx_vld = 1'b0; rx_type = '0; rx_data = '0;
    last_good = '{cyc: 0, kind: 0, t: '0, rid: '0, vid: '0, pay: '0, hd: 1'b0};
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(!rec_done && !len_err && !unk_err, "R1", "pulses in reset",
          {rec_done, len_err, unk_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: record outputs after reset release
    check(rec_reqid == 0 && rec_vendid == 0 && rec_payload == 0 && rec_type == 0
          && !rec_has_data, "R1", "record after reset", rec_payload, 0);

    // R2: short messages
    send(5'd0,  5'd0,  2, 1,  0);
    send(5'd4,  5'd4,  2, 7,  0);
    send(5'd13, 5'd13, 2, 40, 0);
    send(5'd18, 5'd18, 2, 90, 0);
    // R3 / R4: six-beat messages
    send(5'd15, 5'd15, 6, 11, 0);
    send(5'd16, 5'd16, 6, 55, 0);
    // R5 / R6: vendor messages
    send(5'd19, 5'd19, 4, 23, 0);
    send(5'd20, 5'd20, 8, 77, 0);
    send(5'd19, 5'd19, 8, 5,  0);
    // R8: wrong lengths keep the record
    send(5'd2,  5'd2,  3, 60, 1);
    send(5'd15, 5'd15, 5, 61, 1);
    send(5'd19, 5'd19, 6, 62, 1);
    send(5'd20, 5'd20, 1, 63, 1);
    send(5'd9,  5'd9,  9, 64, 1);
    // R9: code changes in mid-run
    send(5'd3,  5'd5,  2, 70, 1);
    send(5'd16, 5'd15, 6, 71, 1);
    // R10: unknown codes
    send(5'd17, 5'd17, 2, 80, 2);
    send(5'd22, 5'd22, 4, 81, 2);
    send(5'd31, 5'd0,  2, 82, 2);
    // R2 / R7: good message after errors
    send(5'd11, 5'd11, 2, 99, 0);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7 R11", "results outstanding", exp_q.size(), 0);
    finish_run();
  end

endmodule